// File: doc/BRIEF.md
# Prefetching DMA Read FIFO Engine

This block copies a contiguous region of memory, given by a start byte address and a byte length, into an internal byte FIFO. Once a block has been started, the engine fetches on its own initiative. It splits the region into read requests of at most `MAX_REQ` bytes. It keeps up to `MAX_OUT` of them in flight, and it issues a new one whenever a tag is free and the FIFO has room for the new request's bytes. Each request carries a tag. The memory side may answer the requests in any order. Responses are held in their tag slot and are moved into the FIFO strictly in issue order.

A consumer takes `POP_BYTES` bytes per pop. A pop either succeeds in full or fails without removing anything. Control consists of start, stop and flush inputs, level outputs for end-of-block and active, and single-cycle pulses for end-of-block, idle and a rejected start. A new block may be started as soon as every request of the current block has been sent, so older responses can still be outstanding when the next block begins.

Top module: `dma_read_fifo`

## Requirements
- R1: After reset no request is valid, `eob_o` is 1, `active_o` is 0 and neither `pop_ok_o` nor `pop_fail_o` is set.
- R2: A block is split into requests at consecutive addresses starting at the block's start address. Each request is `min(MAX_REQ, bytes still to request)` bytes long, so 40 bytes with `MAX_REQ`=16 yields lengths 16, 16 and 8.
- R3: No more than `MAX_OUT` requests are outstanding at once, counted from issue until the response is retired.
- R4: A request is issued only if FIFO occupancy, plus the bytes of all outstanding requests, plus its own length does not exceed `FIFO_BYTES`. Issuing resumes when pops free space.
- R5: Bytes leave the FIFO in ascending address order even when responses arrive out of order. Within a response, byte i sits at `rsp_data_i[8i+7:8i]`. Within a pop, the oldest byte sits at `pop_data_o[7:0]`.
- R6: `eob_o` is 1 exactly when every request of the current block has been issued, whether or not responses are still pending. `active_o` is 1 while a request is outstanding or `eob_o` is 0.
- R7: A start is accepted whenever `eob_o` is 1, even with responses still outstanding. The new block's bytes follow the previous block's bytes in the FIFO.
- R8: A start is rejected when `eob_o` is 0 or the length is zero. A rejected start has no effect on requests or FIFO contents, and `start_err_o` pulses in the next cycle.
- R9: `eob_pulse_o` pulses exactly once per block, in the cycle after the block's last request is accepted.
- R10: `stop_i` halts issuing at once and sets `eob_o`. The data of every request outstanding at the stop is discarded. No end-of-block pulse follows. `idle_pulse_o` still pulses when the last of those responses retires.
- R11: `idle_pulse_o` pulses in the cycle after the last outstanding response retires while `eob_o` is 1. It does not pulse if a start is accepted in that retiring cycle.
- R12: A pop succeeds (`pop_ok_o`=1 in the next cycle) only if the FIFO holds at least `POP_BYTES` bytes. Otherwise `pop_fail_o`=1 and no byte is removed.
- R13: `flush_i` empties the FIFO. Outstanding requests and their space reservations remain, and their data enters the FIFO normally after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a block |
| start_addr_i | input | ADDR_W | Block start byte address |
| start_len_i | input | LEN_W | Block length in bytes |
| stop_i | input | 1 | Halt issuing and discard outstanding data |
| flush_i | input | 1 | Empty the FIFO |
| eob_o | output | 1 | All requests of the block issued |
| active_o | output | 1 | Requests outstanding or still to issue |
| eob_pulse_o | output | 1 | One-cycle end-of-block pulse |
| idle_pulse_o | output | 1 | One-cycle pulse when the engine goes idle |
| start_err_o | output | 1 | One-cycle pulse on a rejected start |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | RL_W | Request length in bytes |
| req_tag_o | output | TAG_W | Request tag |
| rsp_valid_i | input | 1 | Response valid |
| rsp_tag_i | input | TAG_W | Tag of the response |
| rsp_data_i | input | MAX_REQ*8 | Response bytes, byte 0 in the low lane |
| pop_i | input | 1 | Consumer pop request |
| pop_ok_o | output | 1 | Pop succeeded (one cycle later) |
| pop_fail_o | output | 1 | Pop failed (one cycle later) |
| pop_data_o | output | POP_BYTES*8 | Popped bytes |

## Verification
The memory model answers the newest outstanding request first, so an engine that wrote response data into the FIFO in arrival order would produce scrambled bytes at the scoreboard. Held responses show whether the tag cap and the room reservation work. An engine that counted only FIFO occupancy would over-issue past the FIFO size, and one that ignored the cap would issue more than four requests. A response is timed so that a new start lands in the cycle of the last retirement, which exposes an idle pulse that is not suppressed. A stop with held responses shows whether cancelled data leaks into the FIFO or a stray end-of-block pulse follows. Short blocks of 6 and then 2 bytes show whether a failed pop wrongly removes bytes. A flush with a request still in flight shows whether its reservation or its data is lost.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
  typedef struct packed {
    logic busy;
    logic done;
    logic drop;
  } slot_st_t;
endpackage

// File: rtl/dmaf_issue.sv
module dmaf_issue #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_REQ = 16,
  parameter int RL_W    = $clog2(MAX_REQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              stop_i,
  input  logic              can_issue_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [RL_W-1:0]   req_len_o,
  output logic              fire_o,
  output logic              start_acc_o,
  output logic              eob_o,
  output logic              eob_pulse_o,
  output logic              start_err_o
);
  logic [ADDR_W-1:0] next_q, end_q, rem;
  logic last_req;

  assign eob_o       = (next_q == end_q);
  assign rem         = end_q - next_q;
  assign last_req    = (rem <= ADDR_W'(MAX_REQ));
  assign req_len_o   = last_req ? rem[RL_W-1:0] : RL_W'(MAX_REQ);
  assign req_addr_o  = next_q;
  assign req_valid_o = !eob_o && !stop_i && can_issue_i;
  assign fire_o      = req_valid_o && req_ready_i;
  assign start_acc_o = start_i && !stop_i && eob_o && (start_len_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q      <= '0;
      end_q       <= '0;
      eob_pulse_o <= 1'b0;
      start_err_o <= 1'b0;
    end else begin
      if (stop_i) begin
        next_q <= end_q;
      end else if (start_acc_o) begin
        next_q <= start_addr_i;
        end_q  <= start_addr_i + ADDR_W'(start_len_i);
      end else if (fire_o) begin
        next_q <= next_q + ADDR_W'(req_len_o);
      end
      eob_pulse_o <= fire_o && last_req;
      start_err_o <= start_i && !stop_i && !start_acc_o;
    end
  end
endmodule

// File: rtl/dmaf_track.sv
module dmaf_track
  import dmaf_pkg::*;
#(
  parameter int MAX_OUT = 4,
  parameter int MAX_REQ = 16,
  parameter int RL_W    = $clog2(MAX_REQ + 1),
  parameter int TAG_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  parameter int OC_W    = $clog2(MAX_OUT + 1),
  parameter int CNT_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [RL_W-1:0]      fire_len_i,
  input  logic                 stop_i,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [MAX_REQ*8-1:0] rsp_data_i,
  output logic                 slot_free_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic [OC_W-1:0]      out_cnt_o,
  output logic [CNT_W-1:0]     res_bytes_o,
  output logic                 retire_o,
  output logic                 wr_en_o,
  output logic [RL_W-1:0]      wr_len_o,
  output logic [MAX_REQ*8-1:0] wr_data_o
);
  slot_st_t             st_q   [MAX_OUT];
  logic [RL_W-1:0]      len_q  [MAX_OUT];
  logic [MAX_REQ*8-1:0] data_q [MAX_OUT];
  logic [TAG_W-1:0]     head_q, tail_q;

  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(MAX_OUT - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tag_o       = tail_q;
  assign slot_free_o = (out_cnt_o < OC_W'(MAX_OUT));
  assign retire_o    = st_q[head_q].busy && st_q[head_q].done;
  assign wr_en_o     = retire_o && !st_q[head_q].drop;
  assign wr_len_o    = len_q[head_q];
  assign wr_data_o   = data_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < MAX_OUT; s++) begin
        st_q[s]  <= '0;
        len_q[s] <= '0;
      end
      head_q      <= '0;
      tail_q      <= '0;
      out_cnt_o   <= '0;
      res_bytes_o <= '0;
    end else begin
      for (int s = 0; s < MAX_OUT; s++) begin
        if (fire_i && tail_q == TAG_W'(s)) begin
          st_q[s]  <= '{busy: 1'b1, done: 1'b0, drop: 1'b0};
          len_q[s] <= fire_len_i;
        end else begin
          if (retire_o && head_q == TAG_W'(s)) st_q[s].busy <= 1'b0;
          if (rsp_valid_i && rsp_tag_i == TAG_W'(s) && st_q[s].busy) st_q[s].done <= 1'b1;
          if (stop_i && st_q[s].busy) st_q[s].drop <= 1'b1;
        end
      end
      if (fire_i) tail_q <= nxt(tail_q);
      if (retire_o) head_q <= nxt(head_q);
      out_cnt_o   <= out_cnt_o + (fire_i ? OC_W'(1) : '0) - (retire_o ? OC_W'(1) : '0);
      res_bytes_o <= res_bytes_o + (fire_i ? CNT_W'(fire_len_i) : '0)
                                 - (retire_o ? CNT_W'(len_q[head_q]) : '0);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int s = 0; s < MAX_OUT; s++)
      if (rsp_valid_i && rsp_tag_i == TAG_W'(s)) data_q[s] <= rsp_data_i;
  end
endmodule

// File: rtl/dmaf_fifo.sv
module dmaf_fifo #(
  parameter int FIFO_BYTES = 128,
  parameter int MAX_REQ    = 16,
  parameter int POP_BYTES  = 4,
  parameter int RL_W       = $clog2(MAX_REQ + 1),
  parameter int CNT_W      = $clog2(FIFO_BYTES + 1),
  parameter int PTR_W      = $clog2(FIFO_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [RL_W-1:0]        wr_len_i,
  input  logic [MAX_REQ*8-1:0]   wr_data_i,
  input  logic                   pop_i,
  input  logic                   flush_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   pop_ok_o,
  output logic                   pop_fail_o,
  output logic [POP_BYTES*8-1:0] pop_data_o
);
  logic [7:0]       mem_q [FIFO_BYTES];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic             ok;
  logic [CNT_W-1:0] wr_n, rd_n;

  assign ok   = pop_i && (cnt_o >= CNT_W'(POP_BYTES));
  assign wr_n = wr_en_i ? CNT_W'(wr_len_i) : '0;
  assign rd_n = ok ? CNT_W'(POP_BYTES) : '0;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < MAX_REQ; i++)
      if (wr_en_i && RL_W'(i) < wr_len_i) mem_q[wptr_q + PTR_W'(i)] <= wr_data_i[8*i +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_o      <= '0;
      pop_ok_o   <= 1'b0;
      pop_fail_o <= 1'b0;
      pop_data_o <= '0;
    end else begin
      wptr_q     <= wptr_q + PTR_W'(wr_n);
      rptr_q     <= flush_i ? wptr_q : rptr_q + PTR_W'(rd_n);
      cnt_o      <= (flush_i ? '0 : cnt_o - rd_n) + wr_n;
      pop_ok_o   <= ok;
      pop_fail_o <= pop_i && !ok;
      if (ok)
        for (int i = 0; i < POP_BYTES; i++) pop_data_o[8*i +: 8] <= mem_q[rptr_q + PTR_W'(i)];
    end
  end
endmodule

// File: rtl/dma_read_fifo.sv
module dma_read_fifo #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_BYTES = 128,
  parameter int MAX_REQ    = 16,
  parameter int MAX_OUT    = 4,
  parameter int POP_BYTES  = 4,
  localparam int RL_W  = $clog2(MAX_REQ + 1),
  localparam int TAG_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  localparam int OC_W  = $clog2(MAX_OUT + 1),
  localparam int CNT_W = $clog2(FIFO_BYTES + 1),
  localparam int PTR_W = $clog2(FIFO_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      start_addr_i,
  input  logic [LEN_W-1:0]       start_len_i,
  input  logic                   stop_i,
  input  logic                   flush_i,
  output logic                   eob_o,
  output logic                   active_o,
  output logic                   eob_pulse_o,
  output logic                   idle_pulse_o,
  output logic                   start_err_o,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [RL_W-1:0]        req_len_o,
  output logic [TAG_W-1:0]       req_tag_o,
  input  logic                   rsp_valid_i,
  input  logic [TAG_W-1:0]       rsp_tag_i,
  input  logic [MAX_REQ*8-1:0]   rsp_data_i,
  input  logic                   pop_i,
  output logic                   pop_ok_o,
  output logic                   pop_fail_o,
  output logic [POP_BYTES*8-1:0] pop_data_o
);
  logic                 fire, start_acc, can_issue, slot_free, room_ok, retire;
  logic                 wr_en;
  logic [RL_W-1:0]      wr_len;
  logic [MAX_REQ*8-1:0] wr_data;
  logic [OC_W-1:0]      out_cnt;
  logic [CNT_W-1:0]     res_bytes, fifo_cnt;
  logic [CNT_W+1:0]     need;

  // space is reserved at issue: occupancy + in-flight + this request
  assign need      = (CNT_W+2)'(fifo_cnt) + (CNT_W+2)'(res_bytes) + (CNT_W+2)'(req_len_o);
  assign room_ok   = (need <= (CNT_W+2)'(FIFO_BYTES));
  assign can_issue = slot_free && room_ok;
  assign active_o  = (out_cnt != '0) || !eob_o;

  dmaf_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_REQ(MAX_REQ), .RL_W(RL_W)) u_issue (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .start_len_i, .stop_i,
    .can_issue_i(can_issue), .req_ready_i, .req_valid_o, .req_addr_o, .req_len_o,
    .fire_o(fire), .start_acc_o(start_acc), .eob_o, .eob_pulse_o, .start_err_o
  );

  dmaf_track #(.MAX_OUT(MAX_OUT), .MAX_REQ(MAX_REQ), .RL_W(RL_W), .TAG_W(TAG_W),
               .OC_W(OC_W), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .fire_i(fire), .fire_len_i(req_len_o), .stop_i,
    .rsp_valid_i, .rsp_tag_i, .rsp_data_i,
    .slot_free_o(slot_free), .tag_o(req_tag_o), .out_cnt_o(out_cnt),
    .res_bytes_o(res_bytes), .retire_o(retire), .wr_en_o(wr_en),
    .wr_len_o(wr_len), .wr_data_o(wr_data)
  );

  dmaf_fifo #(.FIFO_BYTES(FIFO_BYTES), .MAX_REQ(MAX_REQ), .POP_BYTES(POP_BYTES),
              .RL_W(RL_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_len_i(wr_len), .wr_data_i(wr_data),
    .pop_i, .flush_i, .cnt_o(fifo_cnt), .pop_ok_o, .pop_fail_o, .pop_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_pulse_o <= 1'b0;
    else idle_pulse_o <= retire && (out_cnt == OC_W'(1)) && !fire && eob_o && !start_acc;
  end
endmodule

// File: rtl/dma_read_fifo_chk.sv
module dma_read_fifo_chk #(
  parameter int FIFO_BYTES = 128,
  parameter int MAX_OUT    = 4,
  parameter int OC_W       = 3,
  parameter int CNT_W      = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eob_i,
  input logic             active_i,
  input logic             req_valid_i,
  input logic             fire_i,
  input logic             eob_pulse_i,
  input logic             stop_i,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic [CNT_W-1:0] res_i,
  input logic [OC_W-1:0]  out_cnt_i,
  input logic             pop_ok_i,
  input logic             pop_fail_i
);
  assert_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt_i <= OC_W'(MAX_OUT));
  assert_room_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, fifo_cnt_i} + {1'b0, res_i}) <= (CNT_W+1)'(FIFO_BYTES));
  assert_no_req_at_eob_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_i |-> !req_valid_i);
  assert_inactive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> eob_i);
  assert_eob_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_pulse_i |-> (eob_i && $past(fire_i)));
  assert_stop_no_eob_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !eob_pulse_i);
  assert_pop_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_ok_i && pop_fail_i));
endmodule

bind dma_read_fifo dma_read_fifo_chk #(
  .FIFO_BYTES(FIFO_BYTES), .MAX_OUT(MAX_OUT), .OC_W(OC_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eob_i(eob_o), .active_i(active_o),
  .req_valid_i(req_valid_o), .fire_i(fire), .eob_pulse_i(eob_pulse_o), .stop_i(stop_i),
  .fifo_cnt_i(fifo_cnt), .res_i(res_bytes), .out_cnt_i(out_cnt),
  .pop_ok_i(pop_ok_o), .pop_fail_i(pop_fail_o)
);

// File: tb/tb_dma_read_fifo.sv
module tb_dma_read_fifo;
  localparam int ADDR_W = 32, LEN_W = 16, FIFO_BYTES = 128, MAX_REQ = 16, MAX_OUT = 4, POP_BYTES = 4;
  localparam int RL_W = $clog2(MAX_REQ + 1), TAG_W = 2;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, flush_i = 0, req_ready_i = 1, rsp_valid_i = 0, pop_i = 0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [LEN_W-1:0]  start_len_i = '0;
  logic [TAG_W-1:0]  rsp_tag_i = '0;
  logic [MAX_REQ*8-1:0] rsp_data_i = '0;
  logic eob_o, active_o, eob_pulse_o, idle_pulse_o, start_err_o, req_valid_o, pop_ok_o, pop_fail_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [RL_W-1:0] req_len_o;
  logic [TAG_W-1:0] req_tag_o;
  logic [POP_BYTES*8-1:0] pop_data_o;

  dma_read_fifo dut (.clk_i(clk), .rst_ni(rst_n), .start_i, .start_addr_i, .start_len_i,
    .stop_i, .flush_i, .eob_o, .active_o, .eob_pulse_o, .idle_pulse_o, .start_err_o,
    .req_valid_o, .req_ready_i, .req_addr_o, .req_len_o, .req_tag_o,
    .rsp_valid_i, .rsp_tag_i, .rsp_data_i, .pop_i, .pop_ok_o, .pop_fail_o, .pop_data_o);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, msg, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model
  int pend_tag[$], pend_addr[$], pend_len[$];
  int log_addr[$], log_len[$];
  int issued = 0, issued_bytes = 0, last_fire_edge = -1;
  bit rsp_hold = 0, ooo = 1, ready_mode = 0;
  int rsp_budget = -1;

  initial forever begin
    @(posedge clk); #1;
    rsp_valid_i = 0;
    if (rst_n && !rsp_hold && rsp_budget != 0 && pend_tag.size() > 0) begin
      int k;
      k = (ooo && pend_tag.size() >= 2) ? pend_tag.size() - 1 : 0;
      rsp_valid_i = 1;
      rsp_tag_i = TAG_W'(pend_tag[k]);
      for (int i = 0; i < MAX_REQ; i++)
        rsp_data_i[8*i +: 8] = (i < pend_len[k]) ? mem_byte(32'(pend_addr[k] + i)) : 8'h00;
      pend_tag.delete(k); pend_addr.delete(k); pend_len.delete(k);
      if (rsp_budget > 0) rsp_budget--;
    end
    req_ready_i = ready_mode ? (cyc % 3 != 0) : 1'b1;
  end

  initial forever begin
    @(negedge clk); #1;
    if (rst_n && req_valid_o && req_ready_i) begin
      pend_tag.push_back(int'(req_tag_o)); pend_addr.push_back(int'(req_addr_o));
      pend_len.push_back(int'(req_len_o));
      log_addr.push_back(int'(req_addr_o)); log_len.push_back(int'(req_len_o));
      issued++; issued_bytes += int'(req_len_o);
      last_fire_edge = cyc + 1;
    end
  end

  // pulse monitor
  int eob_cnt = 0, idle_cnt = 0, err_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (eob_pulse_o) begin
      eob_cnt++;
      chk(cyc == last_fire_edge, "R9", "eob pulse cycle", cyc, last_fire_edge);
    end
    if (idle_pulse_o) idle_cnt++;
    if (start_err_o) err_cnt++;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  always @(negedge clk) if (rst_n && pop_ok_o) begin
    for (int i = 0; i < POP_BYTES; i++) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk(pop_data_o[8*i +: 8] === e, "R5", "popped byte", pop_data_o[8*i +: 8], e);
    end
  end

  task automatic start_blk(input int a, input int n, input bit expect_acc);
    @(negedge clk);
    start_i = 1; start_addr_i = 32'(a); start_len_i = 16'(n);
    if (expect_acc) for (int i = 0; i < n; i++) exp_q.push_back(mem_byte(32'(a + i)));
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic pop_once(output bit ok);
    @(negedge clk); pop_i = 1;
    @(negedge clk); pop_i = 0;
    ok = pop_ok_o;
  endtask

  task automatic drain(input int n, input string rq);
    int got = 0, tries = 0;
    bit ok;
    while (got < n && tries < 3000) begin
      pop_once(ok);
      if (ok) got += POP_BYTES;
      tries++;
    end
    chk(got == n, rq, "drained bytes", got, n);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (active_o && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit ok;
    int e0, i0, r0, s0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_valid_o == 0, "R1", "req_valid after reset", req_valid_o, 0);
    chk(eob_o == 1, "R1", "eob after reset", eob_o, 1);
    chk(active_o == 0, "R1", "active after reset", active_o, 0);
    chk(pop_ok_o == 0 && pop_fail_o == 0, "R1", "pop flags after reset", {pop_ok_o, pop_fail_o}, 0);

    // R2 split, R5 order with out-of-order responses
    log_addr.delete(); log_len.delete();
    i0 = idle_cnt;
    start_blk(32'h1000, 40, 1);
    wait_idle();
    chk(log_len.size() == 3, "R2", "request count", log_len.size(), 3);
    if (log_len.size() == 3) begin
      chk(log_len[0] == 16 && log_len[1] == 16 && log_len[2] == 8, "R2", "last length", log_len[2], 8);
      chk(log_addr[1] == 32'h1010 && log_addr[2] == 32'h1020, "R2", "third address", log_addr[2], 32'h1020);
    end
    chk(eob_cnt == 1, "R9", "eob pulses block A", eob_cnt, 1);
    chk(idle_cnt == i0 + 1, "R11", "idle pulse block A", idle_cnt, i0 + 1);
    drain(40, "R5");

    // R3 cap, R4 room
    rsp_hold = 1;
    s0 = issued; r0 = issued_bytes;
    start_blk(32'h2000, 256, 1);
    repeat (30) @(negedge clk);
    chk(issued - s0 == MAX_OUT, "R3", "outstanding while held", issued - s0, MAX_OUT);
    rsp_hold = 0;
    repeat (40) @(negedge clk);
    chk(issued_bytes - r0 == FIFO_BYTES, "R4", "bytes issued without pops", issued_bytes - r0, FIFO_BYTES);
    drain(256, "R4");
    wait_idle();
    chk(issued_bytes - r0 == 256, "R4", "bytes issued after pops", issued_bytes - r0, 256);

    // R6 status, R7 early start
    ready_mode = 1;
    rsp_hold = 1;
    e0 = eob_cnt; r0 = err_cnt;
    start_blk(32'h3000, 32, 1);
    chk(eob_o == 0 && active_o == 1, "R6", "eob/active right after start", {eob_o, active_o}, 1);
    repeat (15) @(negedge clk);
    chk(eob_o == 1 && active_o == 1, "R6", "eob with pending responses", {eob_o, active_o}, 3);
    start_blk(32'h4000, 20, 1);
    chk(err_cnt == r0, "R7", "early start not rejected", err_cnt, r0);
    rsp_hold = 0;
    wait_idle();
    chk(eob_cnt == e0 + 2, "R9", "one eob pulse per block", eob_cnt, e0 + 2);
    drain(52, "R7");
    ready_mode = 0;

    // R8 illegal start
    rsp_hold = 1;
    r0 = err_cnt; s0 = issued;
    start_blk(32'h5000, 64, 1);
    start_blk(32'h6000, 16, 0);
    @(negedge clk);
    chk(err_cnt == r0 + 1, "R8", "start while eob low flagged", err_cnt, r0 + 1);
    rsp_hold = 0;
    wait_idle();
    chk(issued - s0 == 4, "R8", "requests after rejected start", issued - s0, 4);
    start_blk(32'h6100, 0, 0);
    @(negedge clk);
    chk(err_cnt == r0 + 2, "R8", "zero length flagged", err_cnt, r0 + 2);
    chk(active_o == 0, "R8", "zero length leaves idle", active_o, 0);
    drain(64, "R8");
    pop_once(ok);
    chk(ok == 0, "R8", "no data from rejected blocks", ok, 0);

    // R10 stop
    rsp_hold = 1;
    start_blk(32'h7000, 96, 0);
    repeat (10) @(negedge clk);
    s0 = issued; e0 = eob_cnt; i0 = idle_cnt;
    stop_i = 1; @(negedge clk); stop_i = 0;
    repeat (5) @(negedge clk);
    chk(issued == s0 && eob_o == 1, "R10", "no issue after stop", issued, s0);
    rsp_hold = 0;
    wait_idle();
    chk(eob_cnt == e0, "R10", "no eob pulse after stop", eob_cnt, e0);
    chk(idle_cnt == i0 + 1, "R10", "idle after cancelled responses", idle_cnt, i0 + 1);
    pop_once(ok);
    chk(ok == 0, "R10", "cancelled data discarded", ok, 0);

    // R11 idle suppressed by same-cycle start
    rsp_hold = 1;
    start_blk(32'h8000, 16, 1);
    repeat (10) @(negedge clk);
    i0 = idle_cnt;
    rsp_hold = 0; rsp_budget = 1;
    @(negedge clk);
    @(negedge clk);
    start_i = 1; start_addr_i = 32'h9000; start_len_i = 16;
    for (int i = 0; i < 16; i++) exp_q.push_back(mem_byte(32'h9000 + i));
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    chk(idle_cnt == i0, "R11", "idle suppressed by start", idle_cnt, i0);
    rsp_budget = -1;
    wait_idle();
    chk(idle_cnt == i0 + 1, "R11", "idle after second block", idle_cnt, i0 + 1);
    drain(32, "R11");

    // R12 partial pop
    start_blk(32'hA000, 6, 1);
    wait_idle();
    pop_once(ok);
    chk(ok == 1, "R12", "pop with 6 bytes", ok, 1);
    pop_once(ok);
    chk(ok == 0 && pop_fail_o == 1, "R12", "pop with 2 bytes fails", ok, 0);
    start_blk(32'hB000, 2, 1);
    wait_idle();
    pop_once(ok);
    chk(ok == 1, "R12", "bytes kept after failed pop", ok, 1);

    // R13 flush with outstanding request
    start_blk(32'hC000, 32, 1);
    wait_idle();
    rsp_hold = 1;
    start_blk(32'hD000, 16, 1);
    repeat (5) @(negedge clk);
    flush_i = 1;
    repeat (32) void'(exp_q.pop_front());
    @(negedge clk); flush_i = 0;
    rsp_hold = 0;
    wait_idle();
    drain(16, "R13");
    pop_once(ok);
    chk(ok == 0, "R13", "empty after flush and drain", ok, 0);
    chk(exp_q.size() == 0, "R13", "scoreboard empty", exp_q.size(), 0);

    finish_run();
  end
endmodule